// File: doc/BRIEF.md
# Quad DAC Command Decoder and Register Bank

This block sits behind a serial shifter in a four-channel, 12-bit converter. When chip select rises, the shifter presents the assembled command word and the number of bits it captured. The block checks that exactly one full word arrived. It then decodes the four-bit command field at the top of the word and acts on a bank of double-buffered channel registers: one input (staging) register and one output (DAC) register per channel.

Besides the four output codes, the block drives a general-purpose logic output, a shutdown flag and a flag that selects which serial-clock edge the shifter uses for its echo output. A lockout input can prevent shutdown. Pulling the lockout low also cancels a shutdown that is already in force. A synchronous active-low reset and a separate active-low clear both return the bank to its power-up state.

Top module: `quad_dac_cmd_bank`

## Requirements
- R1: A command runs only in a cycle where `cs_rise_i` is high and `bit_cnt_i` equals 16. A strobe that reports any other count changes no register and no output.
- R2: The word carries the command nibble in bits 15:12, as {A1,A0,C1,C0}, and the data in bits 11:0. With C1C0 = 01, the input register of channel A1A0 (00=ch0, 01=ch1, 10=ch2, 11=ch3) takes the data, and no DAC register changes.
- R3: With C1C0 = 11, the selected channel's input register takes the data. In the same cycle every DAC register takes its channel's input value, and the selected channel's DAC register takes the new data.
- R4: Nibble 0100 copies every input register into its DAC register and ignores the data bits.
- R5: Nibble 1000 writes the data into all four input registers and all four DAC registers.
- R6: Nibble 0110 drives `upo_o` high. Nibble 0010 drives it low.
- R7: Nibble 0000 changes no register and no output.
- R8: Nibble 1110 sets `dout_mode_o` to 1 and nibble 1010 sets it to 0. Both also copy every input register into its DAC register.
- R9: Nibble 1100 raises `shdn_o` only if `lock_n_i` is high when the command runs. Input and DAC registers keep their contents.
- R10: While `shdn_o` is high, `lock_n_i` going low drops `shdn_o` at once, without waiting for a clock, and leaves the DAC values unchanged. The shutdown does not come back when `lock_n_i` returns high.
- R11: Any command that writes DAC registers (R3, R4, R5, R8) clears shutdown. Input-only loads, the logic-output commands and the no-operation leave shutdown in force.
- R12: After reset or a one-cycle low on `clr_n_i`, all input and DAC registers read 0, and `upo_o`, `dout_mode_o` and `shdn_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n_i | input | 1 | Synchronous active-low clear of all state |
| lock_n_i | input | 1 | Shutdown lockout; low forbids and cancels shutdown |
| cs_rise_i | input | 1 | One-cycle strobe marking the chip-select rising edge |
| bit_cnt_i | input | 5 | Bits captured by the shifter since chip select fell |
| word_i | input | 16 | Assembled command word |
| dac_o | output | 48 | Four DAC register codes, channel 0 in bits 11:0 |
| upo_o | output | 1 | General-purpose logic output |
| shdn_o | output | 1 | Shutdown state |
| dout_mode_o | output | 1 | Echo edge select: 1 rising, 0 falling |

## Verification
Some properties are checked on every cycle. Outputs stay frozen whenever no valid strobe arrives. A plain update makes each DAC register equal to the input value of the cycle before. An input-only load leaves the DAC register alone. Shutdown rises only after a shutdown command accepted with the lockout high, and a DAC-writing command always ends shutdown. Clear returns everything to zero. Other behaviours need the directed scenarios to show them. These include the channel address mapping, load-and-update ordering, broadcast, discarded short and long words, the immediate wake from the lockout pin, and input values kept across shutdown.

// File: rtl/qdac_pkg.sv
// Package: shared sizes and the decoded-action record for the quad DAC bank.
// Assumes a fixed four-channel layout addressed by a two-bit field.
package qdac_pkg;
    localparam int QDAC_CH = 4;

    // One decoded command, already gated by strobe validity.
    typedef struct packed {
        logic [QDAC_CH-1:0] ld_in;    // one-hot input-register load
        logic               upd_all;  // copy inputs into DAC registers
        logic               bcast;    // data into every input and DAC register
        logic               upo_set;
        logic               upo_clr;
        logic               sd_req;   // shutdown request
        logic               mode_wr;
        logic               mode_val;
    } qdac_act_t;
endpackage

// File: rtl/qdac_cmd_decode.sv
// Module: turns a captured word into one action record.
// Assumes the command nibble sits in the top four bits. Output is all zero
// unless the strobe is high and exactly one word of bits was captured.
module qdac_cmd_decode
    import qdac_pkg::*;
#(
    parameter int WORD_BITS = 16,
    parameter int CNT_W     = 5
) (
    input  logic [WORD_BITS-1:0] word_i,
    input  logic [CNT_W-1:0]     bit_cnt_i,
    input  logic                 cs_rise_i,
    output qdac_act_t            act_o
);
    logic [3:0] nib;
    logic       valid;

    assign nib   = word_i[WORD_BITS-1 -: 4];
    assign valid = cs_rise_i && (bit_cnt_i == CNT_W'(WORD_BITS));

    // Purpose: map the nibble onto action bits.
    always_comb begin
        act_o = '0;
        if (valid) begin
            if (nib[0]) begin
                act_o.ld_in[nib[3:2]] = 1'b1;
                act_o.upd_all         = nib[1];
            end else begin
                unique case (nib[3:1])
                    3'b000: ;
                    3'b001: act_o.upo_clr = 1'b1;
                    3'b010: act_o.upd_all = 1'b1;
                    3'b011: act_o.upo_set = 1'b1;
                    3'b100: act_o.bcast   = 1'b1;
                    3'b101: begin
                        act_o.mode_wr  = 1'b1;
                        act_o.mode_val = 1'b0;
                        act_o.upd_all  = 1'b1;
                    end
                    3'b110: act_o.sd_req = 1'b1;
                    3'b111: begin
                        act_o.mode_wr  = 1'b1;
                        act_o.mode_val = 1'b1;
                        act_o.upd_all  = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/qdac_channel.sv
// Module: one double-buffered channel (input register, then DAC register).
// Assumes ld_in, upd_all and bcast come from a single decoded command.
module qdac_channel #(
    parameter int DAC_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_n_i,
    input  logic                ld_in,
    input  logic                upd_all,
    input  logic                bcast,
    input  logic [DAC_BITS-1:0] data_i,
    output logic [DAC_BITS-1:0] in_q,
    output logic [DAC_BITS-1:0] dac_q
);
    // Purpose: input register takes its own load or a broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n_i)   in_q <= '0;
        else if (ld_in || bcast)  in_q <= data_i;
    end

    // Purpose: DAC register takes a broadcast or the staged input value.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n_i) dac_q <= '0;
        else if (bcast)         dac_q <= data_i;
        else if (upd_all)       dac_q <= ld_in ? data_i : in_q;
    end

    a_r4_update_copies_input: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && upd_all && !ld_in && !bcast) |=> (dac_q == $past(in_q)));

    a_r2_input_only_keeps_dac: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && ld_in && !upd_all && !bcast) |=> $stable(dac_q));
endmodule

// File: rtl/qdac_flags.sv
// Module: logic output, echo-edge mode and shutdown state.
// Assumes lock_n_i is synchronous for the register. The lockout also gates
// the shutdown output directly, so a low lockout clears it at once.
module qdac_flags
    import qdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_n_i,
    input  logic      lock_n_i,
    input  qdac_act_t act_i,
    output logic      upo_o,
    output logic      mode_o,
    output logic      shdn_o
);
    logic shdn_q;
    logic dac_write;

    assign dac_write = act_i.upd_all || act_i.bcast;

    // Purpose: logic output level.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n_i) upo_o <= 1'b0;
        else if (act_i.upo_set) upo_o <= 1'b1;
        else if (act_i.upo_clr) upo_o <= 1'b0;
    end

    // Purpose: echo-edge mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n_i) mode_o <= 1'b0;
        else if (act_i.mode_wr) mode_o <= act_i.mode_val;
    end

    // Purpose: shutdown state; lockout low or a DAC write ends it.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n_i)          shdn_q <= 1'b0;
        else if (!lock_n_i || dac_write) shdn_q <= 1'b0;
        else if (act_i.sd_req)           shdn_q <= 1'b1;
    end

    assign shdn_o = shdn_q && lock_n_i;

    a_r9_shdn_only_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_o) |-> $past(act_i.sd_req && lock_n_i));

    a_r11_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        dac_write |=> !shdn_q);

    a_r6_upo_high: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && act_i.upo_set) |=> upo_o);
endmodule

// File: rtl/quad_dac_cmd_bank.sv
// Module: top of the quad DAC command decoder and register bank.
// Assumes the shifter presents a stable word and bit count with a
// one-cycle strobe at the chip-select rising edge.
module quad_dac_cmd_bank
    import qdac_pkg::*;
#(
    parameter int DAC_BITS = 12,
    localparam int WORD_BITS = DAC_BITS + 4,
    localparam int CNT_W     = $clog2(WORD_BITS + 2),
    localparam int BUS_W     = QDAC_CH * DAC_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_n_i,
    input  logic                 lock_n_i,
    input  logic                 cs_rise_i,
    input  logic [CNT_W-1:0]     bit_cnt_i,
    input  logic [WORD_BITS-1:0] word_i,
    output logic [BUS_W-1:0]     dac_o,
    output logic                 upo_o,
    output logic                 shdn_o,
    output logic                 dout_mode_o
);
    qdac_act_t act;

    qdac_cmd_decode #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_dec (
        .word_i    (word_i),
        .bit_cnt_i (bit_cnt_i),
        .cs_rise_i (cs_rise_i),
        .act_o     (act)
    );

    for (genvar ch = 0; ch < QDAC_CH; ch++) begin : g_ch
        logic [DAC_BITS-1:0] in_val;
        qdac_channel #(.DAC_BITS(DAC_BITS)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_n_i (clr_n_i),
            .ld_in   (act.ld_in[ch]),
            .upd_all (act.upd_all),
            .bcast   (act.bcast),
            .data_i  (word_i[DAC_BITS-1:0]),
            .in_q    (in_val),
            .dac_q   (dac_o[ch*DAC_BITS +: DAC_BITS])
        );
    end

    qdac_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n_i  (clr_n_i),
        .lock_n_i (lock_n_i),
        .act_i    (act),
        .upo_o    (upo_o),
        .mode_o   (dout_mode_o),
        .shdn_o   (shdn_o)
    );

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_i && !(cs_rise_i && bit_cnt_i == CNT_W'(WORD_BITS)))
        |=> ($stable(dac_o) && $stable(upo_o) && $stable(dout_mode_o)));

    a_r12_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |=> (dac_o == '0 && !upo_o && !dout_mode_o && !shdn_o));
endmodule

// File: tb/quad_dac_cmd_bank_bench.sv
// Bench: directed scenarios, one task each, for the quad DAC bank.
module quad_dac_cmd_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        lock_n = 1'b1;
    logic        cs_rise = 1'b0;
    logic [4:0]  bit_cnt = 5'd0;
    logic [15:0] word = 16'h0;
    logic [47:0] dac;
    logic        upo, shdn, mode;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    quad_dac_cmd_bank u_quad_dac_cmd_bank (
        .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .lock_n_i(lock_n),
        .cs_rise_i(cs_rise), .bit_cnt_i(bit_cnt), .word_i(word),
        .dac_o(dac), .upo_o(upo), .shdn_o(shdn), .dout_mode_o(mode)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_dac(input string req, input logic [11:0] c0, input logic [11:0] c1,
                           input logic [11:0] c2, input logic [11:0] c3);
        check(req, {32'h0, 4'h0, 12'h0} | dac, {c3, c2, c1, c0});
    endtask

    // Strobe one word with a chosen bit count; returns at the next falling edge.
    task automatic send(input logic [15:0] w, input logic [4:0] n);
        @(negedge clk);
        word = w; bit_cnt = n; cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0; bit_cnt = 5'd0;
    endtask

    task automatic t_reset();
        chk_dac("R12 reset dac", 12'h0, 12'h0, 12'h0, 12'h0);
        check("R12 reset flags", {45'h0, upo, mode, shdn}, 48'h0);
    endtask

    task automatic t_input_loads();
        send(16'h1123, 16); send(16'h5456, 16); send(16'h9789, 16); send(16'hDABC, 16);
        chk_dac("R2 input only", 12'h0, 12'h0, 12'h0, 12'h0);
        send(16'h4FFF, 16);
        chk_dac("R4 update all", 12'h123, 12'h456, 12'h789, 12'hABC);
    endtask

    task automatic t_load_update();
        send(16'hB321, 16);
        chk_dac("R3 load+update ch2", 12'h123, 12'h456, 12'h321, 12'hABC);
        send(16'h1111, 16); send(16'h7222, 16);
        chk_dac("R3 staged ch0 follows", 12'h111, 12'h222, 12'h321, 12'hABC);
    endtask

    task automatic t_broadcast();
        send(16'h80F0, 16);
        chk_dac("R5 broadcast dac", 12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0);
        send(16'h4000, 16);
        chk_dac("R5 broadcast inputs", 12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0);
    endtask

    task automatic t_bad_count();
        send(16'h1777, 16);
        send(16'h4000, 15);
        chk_dac("R1 short word dropped", 12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0);
        send(16'h4000, 17);
        chk_dac("R1 long word dropped", 12'h0F0, 12'h0F0, 12'h0F0, 12'h0F0);
        send(16'h6000, 8);
        check("R1 short upo dropped", {47'h0, upo}, 48'h0);
        send(16'h4000, 16);
        chk_dac("R1 full word runs", 12'h777, 12'h0F0, 12'h0F0, 12'h0F0);
    endtask

    task automatic t_upo_nop();
        send(16'h6000, 16);
        check("R6 upo high", {47'h0, upo}, 48'h1);
        send(16'h0ABC, 16);
        check("R7 nop keeps upo", {47'h0, upo}, 48'h1);
        chk_dac("R7 nop keeps dac", 12'h777, 12'h0F0, 12'h0F0, 12'h0F0);
        send(16'h2000, 16);
        check("R6 upo low", {47'h0, upo}, 48'h0);
    endtask

    task automatic t_mode();
        send(16'h10AA, 16); send(16'hE000, 16);
        check("R8 mode 1", {47'h0, mode}, 48'h1);
        chk_dac("R8 mode1 updates", 12'h0AA, 12'h0F0, 12'h0F0, 12'h0F0);
        send(16'h10BB, 16); send(16'hA000, 16);
        check("R8 mode 0", {47'h0, mode}, 48'h0);
        chk_dac("R8 mode0 updates", 12'h0BB, 12'h0F0, 12'h0F0, 12'h0F0);
    endtask

    task automatic t_shutdown();
        lock_n = 1'b0;
        send(16'hC000, 16);
        check("R9 locked out", {47'h0, shdn}, 48'h0);
        lock_n = 1'b1;
        send(16'hC000, 16);
        check("R9 shutdown", {47'h0, shdn}, 48'h1);
        send(16'hD3C3, 16);
        send(16'h6000, 16);
        check("R11 load/upo keep shutdown", {47'h0, shdn}, 48'h1);
        chk_dac("R9 dac held", 12'h0BB, 12'h0F0, 12'h0F0, 12'h0F0);
        send(16'h4000, 16);
        check("R11 update wakes", {47'h0, shdn}, 48'h0);
        chk_dac("R9 input kept", 12'h0BB, 12'h0F0, 12'h0F0, 12'h3C3);
    endtask

    task automatic t_wake();
        send(16'hC000, 16);
        check("R10 in shutdown", {47'h0, shdn}, 48'h1);
        lock_n = 1'b0;
        #1;
        check("R10 immediate wake", {47'h0, shdn}, 48'h0);
        chk_dac("R10 dac kept", 12'h0BB, 12'h0F0, 12'h0F0, 12'h3C3);
        @(negedge clk); @(negedge clk);
        lock_n = 1'b1;
        #1;
        check("R10 stays awake", {47'h0, shdn}, 48'h0);
    endtask

    task automatic t_clear();
        send(16'h6000, 16); send(16'hE000, 16);
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        chk_dac("R12 clear dac", 12'h0, 12'h0, 12'h0, 12'h0);
        check("R12 clear flags", {45'h0, upo, mode, shdn}, 48'h0);
        send(16'h4000, 16);
        chk_dac("R12 clear inputs", 12'h0, 12'h0, 12'h0, 12'h0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset(); t_input_loads(); t_load_update(); t_broadcast();
                t_bad_count(); t_upo_nop(); t_mode(); t_shutdown();
                t_wake(); t_clear();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule